// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

A single cell of a lookup-table logic fabric. A 16-bit truth table, supplied on configuration inputs, turns the four data inputs into any Boolean function. An arithmetic mode replaces the table with a full-adder sum and drives a ripple carry to the next cell. A cascade stage can fold a neighbour's result into this cell's result with AND or OR. The cascade stage drives both the combinational output and the cascade output. The combinational output always bypasses the register, so a cell used for pure logic needs no clock.

The storage register behaves as a D, T, JK or SR flip-flop. Each cell picks one of two shared clock lines, one of two shared enables and one of two shared clear lines. The register can also be cleared by the chip-wide active-low reset, set or loaded asynchronously, and cleared or loaded synchronously at a clock edge. In packed mode the register takes its data from `data_i[3]` instead of the table path. The table and the register then serve unrelated functions.

Top module: `logic_cell`

## Requirements
- R1: While `rst_ni` is low, `reg_o` is 0 at once, without a clock edge, and this overrides every other control.
- R2: With `arith_i`=0 and `casc_en_i`=0, `comb_o` equals `lut_mask_i[data_i]`, where `data_i[0]` is the least significant index bit. This holds whatever the register does.
- R3: With `arith_i`=1, the table result is `data_i[0]^data_i[1]^carry_i` and `carry_o` is the majority of those three signals. With `arith_i`=0, `carry_o` is 0.
- R4: With `casc_en_i`=1, the result is the table result ORed with `casc_i` when `casc_or_i`=1, and ANDed with it when `casc_or_i`=0. With `casc_en_i`=0, the table result passes unchanged. `comb_o` and `casc_o` both carry the result.
- R5: `ff_mode_i`=0 selects D mode. At an enabled edge of the selected clock, the register takes its data input. With `packed_i`=0 that input is the `comb_o` value.
- R6: `ff_mode_i`=1 selects T mode, which toggles when the data input is 1. `ff_mode_i`=2 selects JK mode, with J as the data input and K as `data_i[2]`, and 11 toggles. `ff_mode_i`=3 selects SR mode, with S as the data input and R as `data_i[2]`, and R dominates.
- R7: With `packed_i`=1, the register data input is `data_i[3]`, while `comb_o` keeps following the table path.
- R8: `clk_sel_i`=0 clocks the register from `clk_a_i`, and `clk_sel_i`=1 clocks it from `clk_b_i`.
- R9: `ena_sel_i` picks `ena_b_i` (1) or `ena_a_i` (0). While the chosen enable is low, clock edges leave `reg_o` unchanged, including the synchronous load and clear.
- R10: `clr_sel_i` picks `clr_b_i` (1) or `clr_a_i` (0). While the chosen clear is high, `reg_o` is 0 without a clock edge. The unselected clear has no effect.
- R11: With `aload_i` high, the register is set asynchronously to 1 when `aload_pre_i`=1, or to `data_i[3]` when `aload_pre_i`=0.
- R12: At an enabled clock edge, `sclr_i` clears the register. Otherwise `sload_i` loads `data_i[3]`. Otherwise the flip-flop mode update applies.
- R13: Register priority, from highest: reset or selected clear, then asynchronous set or load, then synchronous clear, then synchronous load, then the mode update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Shared clock line A |
| clk_b_i | input | 1 | Shared clock line B |
| rst_ni | input | 1 | Chip-wide asynchronous reset, active low |
| ena_a_i | input | 1 | Shared clock enable A |
| ena_b_i | input | 1 | Shared clock enable B |
| clr_a_i | input | 1 | Shared asynchronous clear A, active high |
| clr_b_i | input | 1 | Shared asynchronous clear B, active high |
| lut_mask_i | input | 16 | Truth table, indexed by data_i |
| ff_mode_i | input | 2 | Flip-flop mode: 0 D, 1 T, 2 JK, 3 SR |
| clk_sel_i | input | 1 | Clock line select |
| ena_sel_i | input | 1 | Enable line select |
| clr_sel_i | input | 1 | Clear line select |
| arith_i | input | 1 | Arithmetic (full-adder) mode |
| casc_en_i | input | 1 | Cascade combine enable |
| casc_or_i | input | 1 | Cascade operator: 1 OR, 0 AND |
| packed_i | input | 1 | Register data from data_i[3] |
| aload_pre_i | input | 1 | Asynchronous action: 1 preset, 0 load data_i[3] |
| data_i | input | 4 | Cell data inputs |
| carry_i | input | 1 | Carry from previous cell |
| casc_i | input | 1 | Cascade from previous cell |
| aload_i | input | 1 | Asynchronous preset/load trigger |
| sload_i | input | 1 | Synchronous load of data_i[3] |
| sclr_i | input | 1 | Synchronous clear |
| comb_o | output | 1 | Combinational (bypass) output |
| reg_o | output | 1 | Registered output |
| carry_o | output | 1 | Carry to next cell |
| casc_o | output | 1 | Cascade to next cell |

## Verification
On every cycle, the assertions check that the adder outputs add up to the count of the three addend bits. They also check that an active clear or reset keeps the register at 0, that an asynchronous set shows up by the next edge, and that a disabled register holds. On every enabled edge they check the D capture and T toggle, and that a synchronous clear wins. Which clock line drives the register, the JK and SR tables, packed operation and the table lookup over all sixteen indices show only in the bench's scenarios. So do releasing a clear while a set is held and ignoring the unselected enable and clear lines. In those scenarios a behavioural model follows the cell through directed sequences and a long mixed run.

// File: rtl/cell_pkg.sv
package cell_pkg;
  typedef enum logic [1:0] {
    FF_D  = 2'd0,
    FF_T  = 2'd1,
    FF_JK = 2'd2,
    FF_SR = 2'd3
  } ff_mode_e;
endpackage

// File: rtl/cell_lut.sv
module cell_lut #(
  parameter int unsigned N_IN = 4,
  localparam int unsigned MASK_W = 1 << N_IN
) (
  input  logic [N_IN-1:0]   data_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              arith_i,
  input  logic              carry_i,
  output logic              f_o,
  output logic              carry_o
);
  logic a, b;
  assign a = data_i[0];
  assign b = data_i[1];

  always_comb begin
    if (arith_i) begin
      f_o     = a ^ b ^ carry_i;
      carry_o = (a & b) | (a & carry_i) | (b & carry_i);
    end else begin
      f_o     = mask_i[data_i];
      carry_o = 1'b0;
    end
  end
endmodule

// File: rtl/cell_casc.sv
module cell_casc (
  input  logic f_i,
  input  logic casc_i,
  input  logic en_i,
  input  logic or_i,
  output logic g_o
);
  always_comb begin
    if (!en_i)     g_o = f_i;
    else if (or_i) g_o = f_i | casc_i;
    else           g_o = f_i & casc_i;
  end
endmodule

// File: rtl/cell_sel.sv
module cell_sel #(
  parameter int unsigned N_SRC = 2,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] clk_i,
  input  logic [N_SRC-1:0] ena_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic [SEL_W-1:0] ena_sel_i,
  input  logic [SEL_W-1:0] clr_sel_i,
  output logic             clk_o,
  output logic             ena_o,
  output logic             clr_o
);
  assign clk_o = clk_i[clk_sel_i];
  assign ena_o = ena_i[ena_sel_i];
  assign clr_o = clr_i[clr_sel_i];
endmodule

// File: rtl/cell_ff.sv
module cell_ff
  import cell_pkg::*;
(
  input  logic     clk_i,
  input  logic     a_clr_i,
  input  logic     a_set_i,
  input  logic     en_i,
  input  logic     sclr_i,
  input  logic     sload_i,
  input  logic     ld_val_i,
  input  logic     din_i,
  input  logic     k_i,
  input  ff_mode_e mode_i,
  output logic     q_o
);
  logic q_nxt;

  always_comb begin
    unique case (mode_i)
      FF_D:  q_nxt = din_i;
      FF_T:  q_nxt = din_i ? ~q_o : q_o;
      FF_JK: begin
        unique case ({din_i, k_i})
          2'b00:   q_nxt = q_o;
          2'b10:   q_nxt = 1'b1;
          2'b01:   q_nxt = 1'b0;
          default: q_nxt = ~q_o;
        endcase
      end
      default: q_nxt = k_i ? 1'b0 : (din_i ? 1'b1 : q_o); // R dominant
    endcase
  end

  always_ff @(posedge clk_i or posedge a_clr_i or posedge a_set_i) begin
    if (a_clr_i)      q_o <= 1'b0;
    else if (a_set_i) q_o <= 1'b1;
    else if (en_i) begin
      if (sclr_i)       q_o <= 1'b0;
      else if (sload_i) q_o <= ld_val_i;
      else              q_o <= q_nxt;
    end
  end
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import cell_pkg::*;
#(
  parameter int unsigned N_IN = 4,
  localparam int unsigned MASK_W = 1 << N_IN
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic              ena_a_i,
  input  logic              ena_b_i,
  input  logic              clr_a_i,
  input  logic              clr_b_i,
  input  logic [MASK_W-1:0] lut_mask_i,
  input  logic [1:0]        ff_mode_i,
  input  logic              clk_sel_i,
  input  logic              ena_sel_i,
  input  logic              clr_sel_i,
  input  logic              arith_i,
  input  logic              casc_en_i,
  input  logic              casc_or_i,
  input  logic              packed_i,
  input  logic              aload_pre_i,
  input  logic [N_IN-1:0]   data_i,
  input  logic              carry_i,
  input  logic              casc_i,
  input  logic              aload_i,
  input  logic              sload_i,
  input  logic              sclr_i,
  output logic              comb_o,
  output logic              reg_o,
  output logic              carry_o,
  output logic              casc_o
);
  localparam int unsigned PK_BIT = N_IN - 1; // packed / load data bit
  localparam int unsigned K_BIT  = N_IN - 2; // K / R input bit

  logic lut_f, casc_g;
  logic reg_clk, reg_en, clr_act;
  logic a_clr, a_set, din;

  cell_lut #(.N_IN(N_IN)) u_lut (
    .data_i  (data_i),
    .mask_i  (lut_mask_i),
    .arith_i (arith_i),
    .carry_i (carry_i),
    .f_o     (lut_f),
    .carry_o (carry_o)
  );

  cell_casc u_casc (
    .f_i    (lut_f),
    .casc_i (casc_i),
    .en_i   (casc_en_i),
    .or_i   (casc_or_i),
    .g_o    (casc_g)
  );

  cell_sel #(.N_SRC(2)) u_sel (
    .clk_i     ({clk_b_i, clk_a_i}),
    .ena_i     ({ena_b_i, ena_a_i}),
    .clr_i     ({clr_b_i, clr_a_i}),
    .clk_sel_i (clk_sel_i),
    .ena_sel_i (ena_sel_i),
    .clr_sel_i (clr_sel_i),
    .clk_o     (reg_clk),
    .ena_o     (reg_en),
    .clr_o     (clr_act)
  );

  // async load decomposed into set / clear of a plain flop
  assign a_clr = ~rst_ni | clr_act | (aload_i & ~aload_pre_i & ~data_i[PK_BIT]);
  assign a_set = aload_i & (aload_pre_i | data_i[PK_BIT]);
  assign din   = packed_i ? data_i[PK_BIT] : casc_g;

  cell_ff u_ff (
    .clk_i    (reg_clk),
    .a_clr_i  (a_clr),
    .a_set_i  (a_set),
    .en_i     (reg_en),
    .sclr_i   (sclr_i),
    .sload_i  (sload_i),
    .ld_val_i (data_i[PK_BIT]),
    .din_i    (din),
    .k_i      (data_i[K_BIT]),
    .mode_i   (ff_mode_e'(ff_mode_i)),
    .q_o      (reg_o)
  );

  assign comb_o = casc_g;
  assign casc_o = casc_g;
endmodule

// File: rtl/logic_cell_chk.sv
module logic_cell_chk #(
  parameter int unsigned N_IN = 4
) (
  input logic            clk_a_i,
  input logic            reg_clk,
  input logic            rst_ni,
  input logic            reg_en,
  input logic            a_clr,
  input logic            a_set,
  input logic            sclr_i,
  input logic            sload_i,
  input logic            packed_i,
  input logic [1:0]      ff_mode_i,
  input logic            arith_i,
  input logic            casc_en_i,
  input logic [N_IN-1:0] data_i,
  input logic            carry_i,
  input logic            comb_o,
  input logic            carry_o,
  input logic            reg_o
);
  p_adder_r3: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (arith_i && !casc_en_i) |->
      ({carry_o, comb_o} == (2'(data_i[0]) + 2'(data_i[1]) + 2'(carry_i))));

  p_clear_r10: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    a_clr |-> !reg_o);

  p_aset_r11: assert property (@(posedge reg_clk) disable iff (!rst_ni)
    (a_set && !a_clr) |=> (reg_o || a_clr));

  p_hold_r9: assert property (@(posedge reg_clk) disable iff (!rst_ni)
    (!reg_en && !a_clr && !a_set) |=> (reg_o == $past(reg_o) || a_clr || a_set));

  p_dcap_r5: assert property (@(posedge reg_clk) disable iff (!rst_ni)
    (reg_en && !a_clr && !a_set && !sclr_i && !sload_i && !packed_i && ff_mode_i == 2'd0)
      |=> (reg_o == $past(comb_o) || a_clr || a_set));

  p_toggle_r6: assert property (@(posedge reg_clk) disable iff (!rst_ni)
    (reg_en && !a_clr && !a_set && !sclr_i && !sload_i && packed_i &&
     data_i[N_IN-1] && ff_mode_i == 2'd1)
      |=> (reg_o == !$past(reg_o) || a_clr || a_set));

  p_sclr_r12: assert property (@(posedge reg_clk) disable iff (!rst_ni)
    (reg_en && sclr_i && !a_clr && !a_set) |=> (!reg_o || a_set));
endmodule

bind logic_cell logic_cell_chk #(.N_IN(N_IN)) u_chk (
  .clk_a_i   (clk_a_i),
  .reg_clk   (reg_clk),
  .rst_ni    (rst_ni),
  .reg_en    (reg_en),
  .a_clr     (a_clr),
  .a_set     (a_set),
  .sclr_i    (sclr_i),
  .sload_i   (sload_i),
  .packed_i  (packed_i),
  .ff_mode_i (ff_mode_i),
  .arith_i   (arith_i),
  .casc_en_i (casc_en_i),
  .data_i    (data_i),
  .carry_i   (carry_i),
  .comb_o    (comb_o),
  .carry_o   (carry_o),
  .reg_o     (reg_o)
);

// File: tb/tb_logic_cell.sv
`timescale 1ns/1ps
module tb_logic_cell;
  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b1;
  logic ena_a = 1'b1, ena_b = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
  logic [15:0] mask = 16'h0;
  logic [1:0] mode = 2'd0;
  logic clk_sel = 1'b0, ena_sel = 1'b0, clr_sel = 1'b0;
  logic arith = 1'b0, casc_en = 1'b0, casc_or = 1'b0, pk = 1'b0, pre = 1'b0;
  logic [3:0] data = 4'h0;
  logic cin = 1'b0, cas = 1'b0, aload = 1'b0, sload = 1'b0, sclr = 1'b0;
  logic comb_o, reg_o, carry_o, casc_o;

  int checks = 0, errors = 0;
  string tag = "R1";
  logic mq = 1'b0, prev_set = 1'b0;
  logic mclk;

  always #10 clk_a = ~clk_a;              // 50 MHz
  initial begin #5; forever #20 clk_b = ~clk_b; end
  assign mclk = clk_sel ? clk_b : clk_a;

  logic_cell dut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .ena_a_i(ena_a), .ena_b_i(ena_b), .clr_a_i(clr_a), .clr_b_i(clr_b),
    .lut_mask_i(mask), .ff_mode_i(mode), .clk_sel_i(clk_sel),
    .ena_sel_i(ena_sel), .clr_sel_i(clr_sel), .arith_i(arith),
    .casc_en_i(casc_en), .casc_or_i(casc_or), .packed_i(pk),
    .aload_pre_i(pre), .data_i(data), .carry_i(cin), .casc_i(cas),
    .aload_i(aload), .sload_i(sload), .sclr_i(sclr),
    .comb_o(comb_o), .reg_o(reg_o), .carry_o(carry_o), .casc_o(casc_o)
  );

  function automatic logic m_table();
    int s;
    s = int'(data[0]) + int'(data[1]) + int'(cin);
    if (arith) return (s % 2) == 1;
    return mask[int'(data)];
  endfunction

  function automatic logic m_carry();
    int s;
    s = int'(data[0]) + int'(data[1]) + int'(cin);
    return arith && (s >= 2);
  endfunction

  function automatic logic m_comb();
    logic f;
    f = m_table();
    if (!casc_en) return f;
    return casc_or ? (f || cas) : (f && cas);
  endfunction

  function automatic logic m_clr();
    logic c;
    c = clr_sel ? clr_b : clr_a;
    return !rst_n || c || (aload && !pre && !data[3]);
  endfunction

  function automatic logic m_set();
    return aload && (pre || data[3]);
  endfunction

  function automatic logic m_next();
    logic d, k, en;
    d  = pk ? data[3] : m_comb();
    k  = data[2];
    en = ena_sel ? ena_b : ena_a;
    if (!en)   return mq;
    if (sclr)  return 1'b0;
    if (sload) return data[3];
    case (mode)
      2'd0: return d;
      2'd1: return d ? !mq : mq;
      2'd2: return (d && k) ? !mq : (d ? 1'b1 : (k ? 1'b0 : mq));
      default: return k ? 1'b0 : (d ? 1'b1 : mq);
    endcase
  endfunction

  always @(posedge mclk) begin
    if (m_clr())      mq <= 1'b0;
    else if (m_set()) mq <= 1'b1;
    else              mq <= m_next();
  end

  task automatic chk(string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s got %0b expected %0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // apply async effects of new inputs, then compare at next clk_a negedge
  task automatic step();
    #1;
    if (m_clr()) mq = 1'b0;
    else if (m_set() && !prev_set) mq = 1'b1;
    prev_set = m_set();
    @(negedge clk_a);
    prev_set = m_set();
    chk("comb_o", comb_o, m_comb());
    chk("casc_o", casc_o, m_comb());
    chk("carry_o", carry_o, m_carry());
    chk("reg_o", reg_o, mq);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #2 rst_n = 1'b0;
    tag = "R1";
    @(negedge clk_a);
    steps(3);
    rst_n = 1'b1; steps(1);
    // set q through D mode, then reset mid-run
    mask = 16'hFFFF; steps(2);
    rst_n = 1'b0; steps(1);
    rst_n = 1'b1; steps(1);

    tag = "R2";
    ena_a = 1'b0;
    foreach (mask[j]) begin end
    mask = 16'hA5C3;
    for (int v = 0; v < 16; v++) begin data = 4'(v); steps(1); end
    mask = 16'h8001;
    for (int v = 0; v < 16; v++) begin data = 4'(v); steps(1); end

    tag = "R3";
    arith = 1'b1;
    for (int v = 0; v < 8; v++) begin
      data = {2'b00, v[1:0]}; cin = v[2]; steps(1);
    end
    arith = 1'b0; cin = 1'b1; data = 4'h3; steps(1);

    tag = "R4";
    casc_en = 1'b1; mask = 16'h00F0;
    for (int v = 0; v < 8; v++) begin
      casc_or = v[0]; cas = v[1]; data = v[2] ? 4'h5 : 4'h1; steps(1);
    end
    casc_en = 1'b0; steps(1);

    tag = "R5";
    ena_a = 1'b1; mode = 2'd0; mask = 16'h6996;
    for (int v = 0; v < 12; v++) begin data = 4'((v * 7) % 16); steps(1); end

    tag = "R6";
    mode = 2'd1; mask = 16'hFFFF; data = 4'h0; steps(3);
    mask = 16'h0000; steps(2);
    pk = 1'b1;
    mode = 2'd2;
    for (int v = 0; v < 8; v++) begin data = {v[0], v[1], 2'b00}; steps(1); end
    data = 4'hC; steps(3);
    mode = 2'd3;
    for (int v = 0; v < 8; v++) begin data = {v[1], v[0], 2'b00}; steps(1); end
    data = 4'hC; steps(1);

    tag = "R7";
    mode = 2'd0; mask = 16'h00FF;
    for (int v = 0; v < 16; v++) begin data = 4'(v); steps(1); end
    pk = 1'b0;

    tag = "R8";
    @(negedge clk_b); #1 clk_sel = 1'b1;
    @(negedge clk_a);
    mask = 16'hFF00;
    for (int v = 0; v < 10; v++) begin data = v[0] ? 4'hF : 4'h0; steps(2); end
    @(negedge clk_b); #1 clk_sel = 1'b0;
    @(negedge clk_a);
    steps(1);

    tag = "R9";
    mask = 16'hFFFF; data = 4'h0; steps(1);
    ena_sel = 1'b1; ena_a = 1'b1; ena_b = 1'b0; mask = 16'h0000; steps(3);
    sclr = 1'b1; steps(1); sclr = 1'b0;
    ena_b = 1'b1; steps(1);
    ena_b = 1'b0; mask = 16'hFFFF; steps(2);
    ena_sel = 1'b0; steps(1);

    tag = "R10";
    clr_sel = 1'b1; clr_a = 1'b1; steps(2);
    clr_a = 1'b0; clr_b = 1'b1; steps(2);
    clr_b = 1'b0; steps(2);

    tag = "R11";
    ena_a = 1'b0; mask = 16'h0000;
    rst_n = 1'b0; steps(1); rst_n = 1'b1; steps(1);
    pre = 1'b1; aload = 1'b1; steps(1); aload = 1'b0; steps(2);
    pre = 1'b0; data = 4'h0; aload = 1'b1; steps(1);
    data = 4'h8; steps(1); data = 4'h0; steps(1); aload = 1'b0; steps(1);
    ena_a = 1'b1;

    tag = "R12";
    sload = 1'b1; data = 4'h8; steps(1);
    sclr = 1'b1; steps(1);
    sclr = 1'b0; steps(1);
    data = 4'h0; steps(1); sload = 1'b0;
    ena_a = 1'b0; sload = 1'b1; data = 4'h8; steps(2); sload = 1'b0; ena_a = 1'b1;

    tag = "R13";
    pre = 1'b1; aload = 1'b1; clr_a = 1'b1; steps(2);
    clr_a = 1'b0; steps(2);
    aload = 1'b0; sclr = 1'b1; sload = 1'b1; data = 4'h8; steps(1);
    sclr = 1'b0; sload = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      mask    = 16'($urandom);
      mode    = 2'($urandom_range(0, 3));
      data    = 4'($urandom);
      {cin, cas, arith, casc_en, casc_or, pk, pre} = 7'($urandom);
      {ena_a, ena_b, ena_sel, clr_sel} = 4'($urandom);
      sclr  = ($urandom_range(0, 5) == 0);
      sload = ($urandom_range(0, 4) == 0);
      aload = ($urandom_range(0, 9) == 0);
      clr_a = ($urandom_range(0, 11) == 0);
      clr_b = ($urandom_range(0, 11) == 0);
      steps(1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: timeout got 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule